// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding and Load Interlock

This block is the forwarding control for an in-order five-stage pipeline with the stages fetch, decode, execute, memory and writeback. For each of the two execute-stage ALU operands, it picks one of three values. The first is the operand latched in the decode/execute register. The second is the ALU result held at the memory stage. The third is the final writeback value, which may come from the ALU or from data memory. When both later stages target the operand's register, the memory-stage value wins, because it is the younger result. A load in the memory stage has no data yet, so it is never a forwarding source.

For decode-stage register-file reads, the block raises a per-operand bypass select. The select is set when a read register is the one that writeback is writing in the same cycle. A load-use detector watches for a load in execute whose destination is a source of the instruction in decode. When it sees one, it raises a stall. The surrounding pipeline responds by holding the PC and the fetch/decode register and by loading a no-op into decode/execute. This inserts one bubble, after which the loaded value reaches execute through the writeback path. Register 0 is a constant zero and takes part in none of this.

The block is purely combinational. All inputs are register indices, write enables, operand-use flags and load flags taken from the pipeline registers.

Top module: `operand_bypass_unit`

## Requirements
- R1: With no write enable asserted in any later stage, both operand selects are 00, both decode bypass selects are 0 and the stall is 0.
- R2: An execute operand that is used and nonzero, and that equals the memory-stage destination while that stage writes a register and is not a load, gets select 10 (memory-stage ALU result).
- R3: An execute operand that is used and nonzero, and that equals the writeback destination while writeback writes a register, gets select 01 (writeback value), provided R2 does not apply.
- R4: When the conditions of R2 and R3 both hold, the select is 10. This gives the newest value across a chain of writes to one register.
- R5: A load in the memory stage never produces select 10. The operand falls back to 01 if writeback matches, and to 00 otherwise.
- R6: A stage whose write enable is 0 is never a forwarding source, whatever its destination index.
- R7: Register index 0 never produces a nonzero operand select, a decode bypass or a stall.
- R8: An operand flagged as unused by the execute-stage instruction gets select 00.
- R9: A decode bypass select is 1 exactly when that read register is nonzero, equals the writeback destination, and writeback writes a register.
- R10: The stall is 1 exactly when the execute-stage instruction is a register-writing load whose nonzero destination equals a decode source that is used.
- R11: A load followed at once by a dependent instruction costs exactly one stall cycle. In the cycle after the bubble, the dependent operand gets select 01.
- R12: The two operand selects are decided independently, so one operand may take 10 while the other takes 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_IDX_W | Decode-stage first read register |
| id_src_b | input | REG_IDX_W | Decode-stage second read register |
| id_need_a | input | 1 | Decode instruction uses its first source |
| id_need_b | input | 1 | Decode instruction uses its second source |
| ex_src_a | input | REG_IDX_W | Execute-stage first operand register |
| ex_src_b | input | REG_IDX_W | Execute-stage second operand register |
| ex_need_a | input | 1 | Execute instruction uses operand A |
| ex_need_b | input | 1 | Execute instruction uses operand B |
| ex_dst | input | REG_IDX_W | Execute-stage destination register |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_IDX_W | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_IDX_W | Writeback destination register |
| wb_wr | input | 1 | Writeback writes a register |
| sel_a | output | 2 | Operand A source: 00 register, 10 memory stage, 01 writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| dec_byp_a | output | 1 | Decode read A takes the writeback value |
| dec_byp_b | output | 1 | Decode read B takes the writeback value |
| ld_stall | output | 1 | Hold PC and fetch/decode, bubble decode/execute |

## Verification
Some properties are checked on every evaluation. A select is never 11. A 10 select always comes from a writing non-load memory stage, and a 01 select never hides an eligible memory-stage match. Unused operands and register 0 stay at 00. A stall or a decode bypass never appears without the matching write enable. What those per-cycle checks cannot show is the exact choice among sources when several stages match. Nor can they show the one-bubble load sequence, which the bench walks cycle by cycle by shifting a load and its consumer through the stages.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      FWD_REG = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_sel_e;

   localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int unsigned REG_IDX_W = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_IDX_W-1:0] src,
   input  logic                 need,
   input  logic [REG_IDX_W-1:0] mem_dst,
   input  logic                 mem_wr,
   input  logic                 mem_load,
   input  logic [REG_IDX_W-1:0] wb_dst,
   input  logic                 wb_wr,
   output fwd_sel_e             sel
);

   logic live;
   logic hit_mem;
   logic hit_wb;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign live = need && (src != '0);
      end else begin : g_zero_soft
         assign live = need;
      end
   endgenerate

   assign hit_mem = live && mem_wr && !mem_load && (mem_dst == src);
   assign hit_wb  = live && wb_wr && (wb_dst == src);

   always_comb begin
      if (hit_mem)     sel = FWD_MEM;
      else if (hit_wb) sel = FWD_WB;
      else             sel = FWD_REG;
   end

   always_comb begin
      p_sel_code_r2: assert (sel != 2'b11)
         else $error("illegal select code");
      p_mem_src_alu_r5: assert (!(sel == FWD_MEM) || (mem_wr && !mem_load && mem_dst == src))
         else $error("memory-stage select without eligible writer");
      p_mem_wins_r4: assert (!(sel == FWD_WB) || !(need && mem_wr && !mem_load && mem_dst == src
                                                 && (!ZERO_HARD || src != '0)))
         else $error("writeback chosen over eligible memory stage");
      p_wb_needs_wr_r6: assert (!(sel == FWD_WB) || (wb_wr && wb_dst == src))
         else $error("writeback select without writer");
      p_unused_quiet_r8: assert (need || sel == FWD_REG)
         else $error("unused operand forwarded");
      p_zero_quiet_r7: assert (!ZERO_HARD || src != '0 || sel == FWD_REG)
         else $error("register zero forwarded");
   end

endmodule

// File: rtl/fwd_decode_bypass.sv
module fwd_decode_bypass #(
   parameter int unsigned REG_IDX_W = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_IDX_W-1:0] src,
   input  logic [REG_IDX_W-1:0] wb_dst,
   input  logic                 wb_wr,
   output logic                 byp
);

   logic src_ok;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign src_ok = (src != '0);
      end else begin : g_zero_soft
         assign src_ok = 1'b1;
      end
   endgenerate

   assign byp = src_ok && wb_wr && (wb_dst == src);

   always_comb begin
      p_byp_needs_wr_r9: assert (!byp || wb_wr)
         else $error("decode bypass without writeback");
      p_byp_zero_r7: assert (!ZERO_HARD || src != '0 || !byp)
         else $error("decode bypass of register zero");
   end

endmodule

// File: rtl/fwd_load_interlock.sv
module fwd_load_interlock
   import fwd_pkg::*;
#(
   parameter int unsigned REG_IDX_W = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [NUM_OPS-1:0][REG_IDX_W-1:0] id_src,
   input  logic [NUM_OPS-1:0]                id_need,
   input  logic [REG_IDX_W-1:0]              ex_dst,
   input  logic                              ex_wr,
   input  logic                              ex_load,
   output logic                              stall
);

   logic [NUM_OPS-1:0] dep;
   logic               dst_ok;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign dst_ok = (ex_dst != '0);
      end else begin : g_zero_soft
         assign dst_ok = 1'b1;
      end
      for (genvar i = 0; i < NUM_OPS; i++) begin : g_dep
         assign dep[i] = id_need[i] && (id_src[i] == ex_dst);
      end
   endgenerate

   assign stall = ex_load && ex_wr && dst_ok && (|dep);

   always_comb begin
      p_stall_load_only_r10: assert (!stall || (ex_load && ex_wr))
         else $error("stall without a writing load");
      p_stall_zero_r7: assert (!ZERO_HARD || ex_dst != '0 || !stall)
         else $error("stall on register zero");
   end

endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_IDX_W = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_IDX_W-1:0] id_src_a,
   input  logic [REG_IDX_W-1:0] id_src_b,
   input  logic                 id_need_a,
   input  logic                 id_need_b,
   input  logic [REG_IDX_W-1:0] ex_src_a,
   input  logic [REG_IDX_W-1:0] ex_src_b,
   input  logic                 ex_need_a,
   input  logic                 ex_need_b,
   input  logic [REG_IDX_W-1:0] ex_dst,
   input  logic                 ex_wr,
   input  logic                 ex_load,
   input  logic [REG_IDX_W-1:0] mem_dst,
   input  logic                 mem_wr,
   input  logic                 mem_load,
   input  logic [REG_IDX_W-1:0] wb_dst,
   input  logic                 wb_wr,
   output logic [1:0]           sel_a,
   output logic [1:0]           sel_b,
   output logic                 dec_byp_a,
   output logic                 dec_byp_b,
   output logic                 ld_stall
);

   generate
      if (REG_IDX_W < 1 || REG_IDX_W > 8) begin : g_bad_width
         $error("REG_IDX_W must lie in 1..8");
      end
   endgenerate

   logic [NUM_OPS-1:0][REG_IDX_W-1:0] ex_src;
   logic [NUM_OPS-1:0]                ex_need;
   logic [NUM_OPS-1:0][REG_IDX_W-1:0] id_src;
   logic [NUM_OPS-1:0]                id_need;
   fwd_sel_e [NUM_OPS-1:0]            sel;
   logic [NUM_OPS-1:0]                byp;

   assign ex_src  = {ex_src_b, ex_src_a};
   assign ex_need = {ex_need_b, ex_need_a};
   assign id_src  = {id_src_b, id_src_a};
   assign id_need = {id_need_b, id_need_a};

   generate
      for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
         fwd_operand_sel #(
            .REG_IDX_W (REG_IDX_W),
            .ZERO_HARD (ZERO_HARD)
         ) u_sel (
            .src      (ex_src[i]),
            .need     (ex_need[i]),
            .mem_dst  (mem_dst),
            .mem_wr   (mem_wr),
            .mem_load (mem_load),
            .wb_dst   (wb_dst),
            .wb_wr    (wb_wr),
            .sel      (sel[i])
         );

         fwd_decode_bypass #(
            .REG_IDX_W (REG_IDX_W),
            .ZERO_HARD (ZERO_HARD)
         ) u_byp (
            .src    (id_src[i]),
            .wb_dst (wb_dst),
            .wb_wr  (wb_wr),
            .byp    (byp[i])
         );
      end
   endgenerate

   fwd_load_interlock #(
      .REG_IDX_W (REG_IDX_W),
      .ZERO_HARD (ZERO_HARD)
   ) u_ilk (
      .id_src  (id_src),
      .id_need (id_need),
      .ex_dst  (ex_dst),
      .ex_wr   (ex_wr),
      .ex_load (ex_load),
      .stall   (ld_stall)
   );

   assign sel_a     = sel[0];
   assign sel_b     = sel[1];
   assign dec_byp_a = byp[0];
   assign dec_byp_b = byp[1];

   always_comb begin
      p_idle_r1: assert (mem_wr || wb_wr || (sel_a == 2'b00 && sel_b == 2'b00))
         else $error("forwarding with no writer");
      p_idle_stall_r1: assert (ex_wr || !ld_stall)
         else $error("stall with no execute writer");
   end

endmodule

// File: tb/operand_bypass_unit_bench.sv
`timescale 1ns/1ps
module operand_bypass_unit_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
   logic id_need_a, id_need_b, ex_need_a, ex_need_b, ex_wr, ex_load;
   logic mem_wr, mem_load, wb_wr;
   logic [1:0] sel_a, sel_b;
   logic dec_byp_a, dec_byp_b, ld_stall;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   operand_bypass_unit u_operand_bypass_unit (
      .id_src_a(id_src_a), .id_src_b(id_src_b),
      .id_need_a(id_need_a), .id_need_b(id_need_b),
      .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
      .ex_need_a(ex_need_a), .ex_need_b(ex_need_b),
      .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
      .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
      .wb_dst(wb_dst), .wb_wr(wb_wr),
      .sel_a(sel_a), .sel_b(sel_b),
      .dec_byp_a(dec_byp_a), .dec_byp_b(dec_byp_b),
      .ld_stall(ld_stall)
   );

   typedef struct packed {
      logic [3:0] req;
      logic [4:0] sa, sb;
      logic       ua, ub;
      logic [4:0] md;
      logic       mw, ml;
      logic [4:0] wd;
      logic       ww;
      logic [1:0] ea, eb;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{4'd1,  5'd1, 5'd2, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00}, // R1 idle
      '{4'd2,  5'd3, 5'd4, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0, 5'd9, 1'b1, 2'b10, 2'b00}, // R2
      '{4'd3,  5'd5, 5'd6, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0, 5'd6, 1'b1, 2'b00, 2'b01}, // R3
      '{4'd4,  5'd1, 5'd1, 1'b1, 1'b1, 5'd1, 1'b1, 1'b0, 5'd1, 1'b1, 2'b10, 2'b10}, // R4 chain on r1
      '{4'd5,  5'd8, 5'd2, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, 5'd8, 1'b1, 2'b01, 2'b00}, // R5 load falls to WB
      '{4'd5,  5'd8, 5'd8, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, 5'd3, 1'b1, 2'b00, 2'b00}, // R5 load, no WB
      '{4'd6,  5'd4, 5'd4, 1'b1, 1'b1, 5'd4, 1'b0, 1'b0, 5'd4, 1'b0, 2'b00, 2'b00}, // R6
      '{4'd7,  5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 2'b00, 2'b00}, // R7
      '{4'd8,  5'd6, 5'd6, 1'b0, 1'b1, 5'd6, 1'b1, 1'b0, 5'd0, 1'b0, 2'b00, 2'b10}, // R8
      '{4'd12, 5'd2, 5'd3, 1'b1, 1'b1, 5'd2, 1'b1, 1'b0, 5'd3, 1'b1, 2'b10, 2'b01}  // R12
   };

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle_all();
      id_src_a = 0; id_src_b = 0; id_need_a = 0; id_need_b = 0;
      ex_src_a = 0; ex_src_b = 0; ex_need_a = 0; ex_need_b = 0;
      ex_dst = 0; ex_wr = 0; ex_load = 0;
      mem_dst = 0; mem_wr = 0; mem_load = 0;
      wb_dst = 0; wb_wr = 0;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   initial begin
      idle_all();
      settle();
      // R1: idle state
      check("R1 sel_a", sel_a, 2'b00);
      check("R1 byp", {dec_byp_a, dec_byp_b}, 2'b00);
      check("R1 stall", {1'b0, ld_stall}, 2'b00);

      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         ex_src_a = VECS[i].sa; ex_src_b = VECS[i].sb;
         ex_need_a = VECS[i].ua; ex_need_b = VECS[i].ub;
         mem_dst = VECS[i].md; mem_wr = VECS[i].mw; mem_load = VECS[i].ml;
         wb_dst = VECS[i].wd; wb_wr = VECS[i].ww;
         settle();
         check($sformatf("R%0d vec%0d sel_a", VECS[i].req, i), sel_a, VECS[i].ea);
         check($sformatf("R%0d vec%0d sel_b", VECS[i].req, i), sel_b, VECS[i].eb);
      end

      // R9: decode bypass
      idle_all();
      id_src_a = 5; id_src_b = 6; wb_dst = 5; wb_wr = 1;
      settle();
      check("R9 hit", {dec_byp_a, dec_byp_b}, 2'b10);
      wb_wr = 0;
      settle();
      check("R9 no write", {dec_byp_a, dec_byp_b}, 2'b00);
      id_src_a = 0; wb_dst = 0; wb_wr = 1;
      settle();
      check("R7 decode zero", {dec_byp_a, dec_byp_b}, 2'b00);

      // R10: load-use stall
      idle_all();
      id_src_b = 7; id_need_b = 1; ex_dst = 7; ex_wr = 1; ex_load = 1;
      settle();
      check("R10 load-use", {1'b0, ld_stall}, 2'b01);
      ex_load = 0;
      settle();
      check("R10 non-load", {1'b0, ld_stall}, 2'b00);
      ex_load = 1; id_need_b = 0;
      settle();
      check("R10 unused src", {1'b0, ld_stall}, 2'b00);
      id_src_a = 0; id_need_a = 1; ex_dst = 0;
      settle();
      check("R7 stall zero", {1'b0, ld_stall}, 2'b00);

      // R11: load r4 then dependent use of r4 in operand A
      idle_all();
      id_src_a = 4; id_need_a = 1; ex_dst = 4; ex_wr = 1; ex_load = 1;
      settle();
      check("R11 cycle1 stall", {1'b0, ld_stall}, 2'b01);
      ex_dst = 0; ex_wr = 0; ex_load = 0;          // bubble in execute
      mem_dst = 4; mem_wr = 1; mem_load = 1;       // load at memory stage
      settle();
      check("R11 cycle2 no stall", {1'b0, ld_stall}, 2'b00);
      ex_src_a = 4; ex_need_a = 1;                 // consumer in execute
      mem_dst = 0; mem_wr = 0; mem_load = 0;       // bubble at memory stage
      wb_dst = 4; wb_wr = 1;                       // load at writeback
      id_src_a = 0; id_need_a = 0;
      settle();
      check("R11 cycle3 sel_a", sel_a, 2'b01);
      check("R11 cycle3 stall", {1'b0, ld_stall}, 2'b00);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule